// File: doc/BRIEF.md
# Receive Frame Staging Buffer with Whole-Frame Drop

This block sits between a MAC receive byte stream and the data FIFO that host logic reads. Every byte from the MAC comes with a start-of-frame flag and an end-of-frame flag. Bytes first land in a staging FIFO of fixed depth. A frame counts as committed once its end-of-frame byte has been stored. From then on its bytes move one per cycle into a larger receive data FIFO, and only while that FIFO has room. When the data FIFO is full, arriving bytes keep piling up in the staging FIFO. If the staging FIFO is full when a byte of a frame arrives, the whole frame is lost. Bytes of it already stored are withdrawn by moving the staging write pointer back to the frame's first entry. The rest of the frame is ignored, and a saturating dropped-frame counter goes up by one.

The MAC side cannot be stalled, so it has a valid flag only. The host read side is valid/ready. A byte is handed over on a cycle where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_eof` hold their values. A skip request starts a fast-forward. While it runs, the data FIFO throws away entries through the next end-of-frame marker, then the busy flag clears by itself. Staging occupancy is internal and plays no part in the data FIFO's room decision.

Top module: `rx_frame_stager`

## Requirements
- R1: Bytes reach the read port in arrival order. Each is marked `rd_eof`=1 only on the last byte of its frame. Bytes of a frame are not moved to the data FIFO until its end-of-frame byte is in the staging FIFO.
- R2: The staging FIFO holds at most STG_DEPTH (default 128) bytes. A byte is stored only if staging occupancy at the start of its cycle is below STG_DEPTH.
- R3: One committed byte moves per cycle, and only while data FIFO occupancy at the start of that cycle is below DAT_DEPTH. Otherwise bytes wait in staging.
- R4: A byte that arrives with staging full drops its whole frame. No byte of that frame ever appears on the read port.
- R5: After such a drop, further bytes of that frame are ignored. The frame ends at a byte with end-of-frame set, or when a byte with start-of-frame set arrives, which is then handled as a new frame.
- R6: `drop_count` is 0 after reset, rises by one for each lost frame, and saturates at 2^CNT_W-1.
- R7: A `drop_rd` pulse clears `drop_count` on the next edge. A drop in that same cycle makes the result 1.
- R8: A `ffwd_req` pulse while `ffwd_busy` is 0 sets `ffwd_busy`. While busy, the data FIFO discards one entry per cycle. After the entry with end-of-frame set is discarded, `ffwd_busy` returns to 0. If the FIFO is empty, the skip waits for data. A request while busy is ignored.
- R9: While `ffwd_busy` is 1, `rd_valid` is 0 and `rd_data` is 0, and `rd_ready` does not consume data.
- R10: While `rd_valid`=1 and `rd_ready`=0, and no skip is requested, `rd_valid`, `rd_data` and `rd_eof` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | MAC byte present this cycle |
| in_data | input | 8 | MAC byte |
| in_sof | input | 1 | Byte is the first of its frame |
| in_eof | input | 1 | Byte is the last of its frame |
| rd_valid | output | 1 | Data FIFO offers a byte |
| rd_ready | input | 1 | Host takes the offered byte |
| rd_data | output | 8 | Offered byte, 0 when not valid |
| rd_eof | output | 1 | Offered byte ends its frame |
| ffwd_req | input | 1 | Pulse: skip to the start of the next frame |
| ffwd_busy | output | 1 | Skip in progress |
| drop_rd | input | 1 | Pulse: counter read, clears it |
| drop_count | output | CNT_W | Saturating count of lost frames |

## Verification
The assertions assume the MAC stream is well formed: every frame opens with a start-of-frame byte and closes with exactly one end-of-frame byte, and a new frame never opens before the previous one has closed, except after a drop. The stimulus follows this rule. It builds every frame from a length and a base value, sets start-of-frame on the first byte and end-of-frame on the last, and never interleaves frames. Frames are kept shorter than the staging depth, because a longer frame can never be committed. The host side, the skip request and the counter read may change freely in any cycle.

// File: rtl/rx_stage_pkg.sv
package rx_stage_pkg;
  localparam int BYTE_W = 8;
  typedef struct packed {
    logic              eof;
    logic [BYTE_W-1:0] data;
  } rx_byte_t;
endpackage

// File: rtl/rx_stage_buf.sv
module rx_stage_buf
  import rx_stage_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  logic     in_sof,
  input  logic     in_eof,
  input  logic [BYTE_W-1:0] in_data,
  input  logic     mv_room,
  output logic     mv_valid,
  output rx_byte_t mv_entry,
  output logic     frame_lost
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  rx_byte_t    mem [DEPTH];
  logic [AW:0] wr_q, cm_q, rd_q;
  logic        discard_q;
  logic [AW:0] occ;
  logic        take, full, accept;

  assign occ        = wr_q - rd_q;
  assign full       = (occ == FULL_LVL);
  assign take       = in_valid && (!discard_q || in_sof);
  assign accept     = take && !full;
  assign frame_lost = take && full;
  assign mv_valid   = (cm_q != rd_q) && mv_room;
  assign mv_entry   = mem[rd_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_q[AW-1:0]] <= '{eof: in_eof, data: in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q      <= '0;
      cm_q      <= '0;
      rd_q      <= '0;
      discard_q <= 1'b0;
    end else begin
      if (mv_valid) rd_q <= rd_q + 1'b1;
      if (accept) begin
        wr_q      <= wr_q + 1'b1;
        discard_q <= 1'b0;
        if (in_eof) cm_q <= wr_q + 1'b1;
      end else if (frame_lost) begin
        wr_q      <= cm_q;
        discard_q <= !in_eof;
      end else if (in_valid && discard_q && in_eof) begin
        discard_q <= 1'b0;
      end
    end
  end

  p_stg_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_LVL);
  p_rollback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lost |=> (wr_q == cm_q));
  p_discard_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && discard_q && !in_sof) |=> (wr_q == $past(wr_q)));
  p_commit_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> ((cm_q - rd_q) <= occ));
endmodule

// File: rtl/rx_data_fifo.sv
module rx_data_fifo
  import rx_stage_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_byte_t push_entry,
  output logic     room,
  output logic     rd_valid,
  input  logic     rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic     rd_eof,
  input  logic     skip_req,
  output logic     skip_busy
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  rx_byte_t    mem [DEPTH];
  logic [AW:0] wr_q, rd_q, cnt;
  logic        busy_q, nonempty, pop;
  rx_byte_t    head;

  assign cnt       = wr_q - rd_q;
  assign nonempty  = (cnt != '0);
  assign room      = (cnt != FULL_LVL);
  assign head      = mem[rd_q[AW-1:0]];
  assign rd_valid  = nonempty && !busy_q;
  assign rd_data   = rd_valid ? head.data : '0;
  assign rd_eof    = rd_valid && head.eof;
  assign pop       = busy_q ? nonempty : (rd_valid && rd_ready);
  assign skip_busy = busy_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      if (busy_q && nonempty && head.eof) busy_q <= 1'b0;
      else if (!busy_q && skip_req)       busy_q <= 1'b1;
    end
  end

  p_dfifo_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < FULL_LVL));
  p_ffwd_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(nonempty && head.eof));
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!rd_valid && rd_data == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !skip_req) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_eof)));
endmodule

// File: rtl/rx_drop_ctr.sv
module rx_drop_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] base;

  assign base = clr ? '0 : count;

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= (base == MAX) ? MAX : base + 1'b1;
    else          count <= base;
  end

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAX && !clr) |=> (count == MAX));
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != MAX) |=> (count == $past(count) + 1'b1));
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (count == '0));
endmodule

// File: rtl/rx_frame_stager.sv
module rx_frame_stager
  import rx_stage_pkg::*;
#(
  parameter int STG_DEPTH = 128,
  parameter int DAT_DEPTH = 512,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic             rd_eof,
  input  logic             ffwd_req,
  output logic             ffwd_busy,
  input  logic             drop_rd,
  output logic [CNT_W-1:0] drop_count
);
  logic     mv_valid, dat_room, frame_lost;
  rx_byte_t mv_entry;

  rx_stage_buf #(.DEPTH(STG_DEPTH)) i_stage (
    .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_data,
    .mv_room(dat_room), .mv_valid, .mv_entry, .frame_lost
  );

  rx_data_fifo #(.DEPTH(DAT_DEPTH)) i_data (
    .clk, .rst_n, .push(mv_valid), .push_entry(mv_entry), .room(dat_room),
    .rd_valid, .rd_ready, .rd_data, .rd_eof,
    .skip_req(ffwd_req), .skip_busy(ffwd_busy)
  );

  rx_drop_ctr #(.W(CNT_W)) i_drop (
    .clk, .rst_n, .inc(frame_lost), .clr(drop_rd), .count(drop_count)
  );
endmodule

// File: tb/test_rx_frame_stager.sv
module test_rx_frame_stager;
  localparam int STG = 128;
  localparam int DAT = 64;
  localparam int CW  = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic rd_ready = 0, ffwd_req = 0, drop_rd = 0;
  logic rd_valid, rd_eof, ffwd_busy;
  logic [7:0] rd_data;
  logic [CW-1:0] drop_count;

  always #2.5 clk = ~clk;

  rx_frame_stager #(.STG_DEPTH(STG), .DAT_DEPTH(DAT), .CNT_W(CW)) i_rx_frame_stager (
    .clk, .rst_n, .in_valid, .in_data, .in_sof, .in_eof,
    .rd_valid, .rd_ready, .rd_data, .rd_eof,
    .ffwd_req, .ffwd_busy, .drop_rd, .drop_count
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int  m_stg[$];
  int  m_dat[$];
  int  m_commit, m_cnt, v_occ, v_docc, v_head, v_c;
  bit  m_disc, m_busy, v_busy0, v_mv, v_pop, v_inc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stg.delete(); m_dat.delete();
      m_commit = 0; m_cnt = 0; m_disc = 0; m_busy = 0;
    end else begin
      v_occ = m_stg.size(); v_docc = m_dat.size(); v_busy0 = m_busy;
      v_mv  = (m_commit > 0) && (v_docc < DAT);
      v_pop = v_busy0 ? (v_docc > 0) : ((v_docc > 0) && rd_ready);
      v_head = (v_docc > 0) ? m_dat[0] : 0;
      if (v_pop) void'(m_dat.pop_front());
      if (v_busy0 && v_docc > 0 && v_head[8]) m_busy = 0;
      else if (!v_busy0 && ffwd_req) m_busy = 1;
      if (v_mv) begin m_dat.push_back(m_stg.pop_front()); m_commit--; end
      v_inc = 0;
      if (in_valid && (!m_disc || in_sof)) begin
        if (v_occ < STG) begin
          m_stg.push_back({23'd0, in_eof, in_data});
          if (in_eof) m_commit = m_stg.size();
          m_disc = 0;
        end else begin
          v_inc = 1;
          while (m_stg.size() > m_commit) void'(m_stg.pop_back());
          m_disc = !in_eof;
        end
      end else if (in_valid && m_disc && in_eof) m_disc = 0;
      v_c = drop_rd ? 0 : m_cnt;
      if (v_inc) v_c = (v_c == MAXC) ? MAXC : v_c + 1;
      m_cnt = v_c;
    end
  end

  // compare each cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(rd_valid == (m_dat.size() > 0 && !m_busy), "R1/R3 rd_valid", rd_valid, m_dat.size() > 0 && !m_busy);
      if (rd_valid && m_dat.size() > 0) begin
        check(rd_data == m_dat[0][7:0], "R1 rd_data", rd_data, m_dat[0][7:0]);
        check(rd_eof == m_dat[0][8], "R1 rd_eof", rd_eof, m_dat[0][8]);
      end
      check(ffwd_busy == m_busy, "R8 ffwd_busy", ffwd_busy, m_busy);
      if (ffwd_busy) check(rd_data == 0 && !rd_valid, "R9 quiet while busy", rd_data, 0);
      check(drop_count == m_cnt, "R6 drop_count", drop_count, m_cnt);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send_frame(input int len, input int base, input int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(base + i);
      in_sof = (i == 0); in_eof = (i == len - 1);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
      end
    end
    @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_drop_rd();
    @(negedge clk); drop_rd = 1;
    @(negedge clk); drop_rd = 0;
  endtask

  task automatic pulse_ffwd();
    @(negedge clk); ffwd_req = 1;
    @(negedge clk); ffwd_req = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_valid == 0, "R9 reset rd_valid", rd_valid, 0);
    check(ffwd_busy == 0, "R8 reset ffwd_busy", ffwd_busy, 0);
    check(drop_count == 0, "R6 reset drop_count", drop_count, 0);
    rst_n = 1;

    // R1: frames flow straight through
    rd_ready = 1;
    for (int f = 0; f < 4; f++) send_frame(5 + f * 7, f * 40, f % 2);
    idle(20);
    check(drop_count == 0, "R1 no drops on free flow", drop_count, 0);

    // R2/R3/R4/R5: host stalls, staging overflows, frames lost whole
    rd_ready = 0;
    for (int f = 0; f < 10; f++) send_frame(30, 16 + f, 0);
    idle(5);
    check(drop_count == 4, "R4 four frames lost", drop_count, 4);
    pulse_drop_rd();
    check(drop_count == 0, "R7 cleared by read", drop_count, 0);
    rd_ready = 1; idle(250);
    check(rd_valid == 0, "R4 drained, no partial bytes", rd_valid, 0);

    // R6: saturation
    rd_ready = 0;
    for (int f = 0; f < 40; f++) send_frame(12, f * 3, 0);
    idle(3);
    check(drop_count == MAXC, "R6 saturated", drop_count, MAXC);
    // R7: read with simultaneous drop gives 1
    @(negedge clk); drop_rd = 1; in_valid = 1; in_sof = 1; in_eof = 1; in_data = 8'h55;
    @(negedge clk); drop_rd = 0; in_valid = 0; in_sof = 0; in_eof = 0;
    check(drop_count == 1, "R7 clear plus drop", drop_count, 1);
    pulse_drop_rd();
    rd_ready = 1; idle(250);

    // R8/R9: skip rest of a partly read frame
    rd_ready = 0;
    send_frame(10, 8'h10, 0);
    send_frame(6, 8'hA0, 0);
    idle(30);
    rd_ready = 1; idle(3); rd_ready = 0;
    pulse_ffwd();
    check(ffwd_busy == 1, "R8 busy after request", ffwd_busy, 1);
    check(rd_data == 0, "R9 zero data while busy", rd_data, 0);
    idle(12);
    check(ffwd_busy == 0, "R8 busy self-clears", ffwd_busy, 0);
    check(rd_valid && rd_data == 8'hA0, "R8 next frame start", rd_data, 8'hA0);
    check(rd_valid && rd_data == 8'hA0, "R10 held while not ready", rd_data, 8'hA0);
    rd_ready = 1; idle(20);

    // R8: skip on empty FIFO waits and eats the next frame
    pulse_ffwd();
    rd_ready = 0;
    send_frame(4, 8'hC0, 0);
    send_frame(3, 8'hD0, 0);
    idle(15);
    check(ffwd_busy == 0, "R8 skip finished after arrival", ffwd_busy, 0);
    check(rd_data == 8'hD0, "R8 first frame skipped", rd_data, 8'hD0);
    rd_ready = 1; idle(20);

    // random mix, reference compared every cycle
    for (int k = 0; k < 300; k++) begin
      fork
        send_frame(1 + ($urandom % 40), $urandom % 256, $urandom % 2);
        begin
          for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            rd_ready = ($urandom % 4) == 0;
            ffwd_req = ($urandom % 64) == 0;
            drop_rd  = ($urandom % 32) == 0;
          end
          @(negedge clk); ffwd_req = 0; drop_rd = 0;
        end
      join
    end
    rd_ready = 1; ffwd_req = 0; drop_rd = 0;
    idle(400);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule